// File: doc/BRIEF.md
# NAND Page Copy-Back Sequencer

This block runs an on-chip page copy inside a NAND flash device from the host side of an 8-bit command/address/data bus. A one-cycle start pulse hands it a source row, a target row, a flag that asks for the buffered page to be streamed back, and a small fixed set of column patches. Each patch is an enable, a start column, a byte count and a fill byte. The block drives the latch-enable strobes, the write and read strobes and the bus. It also watches the device's ready line.

The copy takes two command phases. The first loads the source page into the device's page buffer and waits out the read busy time. After that, the block can read the whole buffer out. The second phase names the target page and writes each enabled patch into the buffer as a random-data-input burst. It then starts the program and waits out the program busy time. Last, it reads the status byte and reports pass or fail.

Before any bus activity, the block checks the request. A request with mismatched odd/even page selection, or with a patch that runs outside the page, ends at once with the illegal flag. A busy wait that lasts too long ends the copy with the timeout flag.

Top module: `nand_cb_seq`

## Requirements
- R1: After start, the first bus cycles are, in this order: command 00h, five address cycles (column low = 00h, column high = 00h, then the source row bytes from least to most significant), and then command 35h. A command cycle has CLE high. An address cycle has ALE high.
- R2: No write or read strobe cycle completes while the ready line is low. Each busy wait begins after the 35h and 10h confirms and ends only once the ready line reads high.
- R3: When the readout flag is set, the block reads exactly 2112 bytes with RE# pulses between the first busy wait and the second phase. It presents each byte on `rd_data` with a one-cycle `rd_valid`, in column order from 0. When the flag is clear, `rd_valid` never asserts.
- R4: The second phase is command 85h, then five target address cycles in the same byte order as R1, then the patch bursts, then command 10h.
- R5: Each enabled patch is written in index order as command 85h, column low byte, column high byte, and then `len` data cycles of its fill byte, with CLE and ALE both low. A disabled patch emits nothing, and its fields are not checked.
- R6: After 10h and the program busy wait, the block issues command 70h and reads one byte. If bit 0 of that byte is 1, `fail` is raised. Otherwise `pass` is raised.
- R7: If bit 6 of the source row differs from bit 6 of the target row, the block raises `illegal` and drives no bus cycle at all.
- R8: If any enabled patch has `len` = 0 or column + `len` > 2112, the block raises `illegal` and drives no bus cycle. A patch that ends exactly at column 2111 is accepted.
- R9: If the ready line stays low for longer than the timeout on either busy wait, the copy stops, `timeout` is raised and no further bus cycles follow.
- R10: Each write cycle holds WE# low for exactly WE_LOW clocks, with CLE, ALE and the bus stable while it is low. CLE and ALE are never high together. WE# and RE# are never low together.
- R11: `busy` rises the cycle after an accepted start. `done` pulses for one cycle with exactly one of pass, fail, illegal or timeout set, and `busy` is low in the following cycle. The result flags hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken when idle |
| src_row | input | 24 | Source page row address |
| dst_row | input | 24 | Target page row address |
| readout_en | input | 1 | Stream the buffered page back after the first phase |
| patch_en | input | 2 | Enable per patch |
| patch_col | input | 24 | Start column per patch, 12 bits each |
| patch_len | input | 16 | Byte count per patch, 8 bits each |
| patch_fill | input | 16 | Fill byte per patch |
| io_in | input | 8 | Bus value driven by the device |
| rb | input | 1 | Ready line, 1 = ready |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Bus value driven by the block |
| io_oe | output | 1 | Bus output enable |
| rd_data | output | 8 | Read-out page byte |
| rd_valid | output | 1 | `rd_data` valid strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Program succeeded |
| fail | output | 1 | Status bit 0 was set |
| illegal | output | 1 | Request rejected |
| timeout | output | 1 | A busy wait expired |

## Verification
A plain copy with readout off and no patches checks the bare two-phase command and address order against the expected log. A copy with readout on checks the 2112-byte stream against the page pattern in the device model. It also shows that no strobe is issued during a busy wait. A patched copy has one patch disabled with out-of-range fields and one patch ending at the last column. It checks index ordering, skipping and the boundary acceptance. Separate runs cover the following:
- a status byte with bit 0 set, which must give fail rather than pass;
- mismatched odd/even row bits;
- a patch that runs past the end of the page;
- a zero-length patch;
- a ready line held low, which must give timeout.

The illegal runs must leave the bus idle, and the timeout run must stop after the 35h command.

// File: rtl/nand_cb_pkg.sv
// Shared definitions for the copy-back sequencer: bus cycle kinds and
// device command codes. Assumes a byte-wide command/address/data bus.
package nand_cb_pkg;
    localparam int COL_W = 12;

    localparam logic [7:0] OP_LOAD     = 8'h00;
    localparam logic [7:0] OP_LOAD_GO  = 8'h35;
    localparam logic [7:0] OP_WRITE    = 8'h85;
    localparam logic [7:0] OP_WRITE_GO = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;

    typedef enum logic [1:0] {
        BK_CMD,
        BK_ADDR,
        BK_DIN,
        BK_DOUT
    } bus_kind_t;
endpackage

// File: rtl/nand_cb_cycle.sv
// Bus cycle engine. It runs one command, address, data-in or data-out cycle
// for each go pulse. The strobe is low for LOW_CLKS clocks and then high for
// HIGH_CLKS clocks. CLE/ALE and the bus hold through both parts. A read
// cycle samples io_in on the last low clock. go is taken only when idle.
module nand_cb_cycle
    import nand_cb_pkg::*;
#(
    parameter int LOW_CLKS  = 2,
    parameter int HIGH_CLKS = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  bus_kind_t kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic      done,
    output logic      rvalid,
    output logic [7:0] rdata,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] io_out,
    output logic      io_oe
);
    localparam int MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

    phase_t    phase;
    logic [CW-1:0] cnt;
    bus_kind_t kind_q;
    logic [7:0] byte_q;

    // Cycle timing: accept, hold the strobe low, then release and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            kind_q <= BK_CMD;
            byte_q <= '0;
            done   <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            done   <= 1'b0;
            rvalid <= 1'b0;
            case (phase)
                PH_IDLE: if (go) begin
                    kind_q <= kind;
                    byte_q <= wbyte;
                    cnt    <= CW'(LOW_CLKS - 1);
                    phase  <= PH_LOW;
                end
                PH_LOW: if (cnt == '0) begin
                    phase <= PH_HIGH;
                    cnt   <= CW'(HIGH_CLKS - 1);
                    if (kind_q == BK_DOUT) begin
                        rdata  <= io_in;
                        rvalid <= 1'b1;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (cnt == '0) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin decode from the held cycle kind and phase.
    always_comb begin
        cle    = (phase != PH_IDLE) && (kind_q == BK_CMD);
        ale    = (phase != PH_IDLE) && (kind_q == BK_ADDR);
        io_oe  = (phase != PH_IDLE) && (kind_q != BK_DOUT);
        we_n   = !((phase == PH_LOW) && (kind_q != BK_DOUT));
        re_n   = !((phase == PH_LOW) && (kind_q == BK_DOUT));
        io_out = byte_q;
    end
endmodule

// File: rtl/nand_cb_wait.sv
// Busy waiter. After go it ignores the ready line for GUARD_CLKS clocks so
// that the device has time to drop it. It then polls a two-flop synchronised
// copy. ok pulses when ready is seen. tout pulses if the line stays low for
// TIMEOUT_CLKS clocks of polling.
module nand_cb_wait #(
    parameter int GUARD_CLKS   = 4,
    parameter int TIMEOUT_CLKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rb,
    output logic ok,
    output logic tout
);
    localparam int TW = $clog2(((TIMEOUT_CLKS > GUARD_CLKS) ? TIMEOUT_CLKS : GUARD_CLKS) + 1);

    typedef enum logic [1:0] {W_IDLE, W_GUARD, W_POLL} wst_t;

    wst_t          wst;
    logic [TW-1:0] cnt;
    logic          rb_m, rb_s;

    // Synchronise the asynchronous ready line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_m <= 1'b0;
            rb_s <= 1'b0;
        end else begin
            rb_m <= rb;
            rb_s <= rb_m;
        end
    end

    // Guard interval, then poll with a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst  <= W_IDLE;
            cnt  <= '0;
            ok   <= 1'b0;
            tout <= 1'b0;
        end else begin
            ok   <= 1'b0;
            tout <= 1'b0;
            case (wst)
                W_IDLE: if (go) begin
                    wst <= W_GUARD;
                    cnt <= '0;
                end
                W_GUARD: if (cnt == TW'(GUARD_CLKS - 1)) begin
                    wst <= W_POLL;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                W_POLL: if (rb_s) begin
                    ok  <= 1'b1;
                    wst <= W_IDLE;
                end else if (cnt == TW'(TIMEOUT_CLKS - 1)) begin
                    tout <= 1'b1;
                    wst  <= W_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: wst <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_cb_check.sv
// Request validator. It is purely combinational. It flags a parity mismatch
// between the source and target odd/even row bits, and any enabled patch
// that is empty or runs past the last column of the page.
module nand_cb_check
    import nand_cb_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int NPATCH     = 2,
    parameter int LEN_W      = 8
) (
    input  logic                    src_par,
    input  logic                    dst_par,
    input  logic [NPATCH-1:0]       pen,
    input  logic [NPATCH*COL_W-1:0] pcol,
    input  logic [NPATCH*LEN_W-1:0] plen,
    output logic                    bad
);
    logic [NPATCH-1:0] pbad;

    for (genvar g = 0; g < NPATCH; g++) begin : g_patch
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] len;
        assign col = pcol[g*COL_W +: COL_W];
        assign len = plen[g*LEN_W +: LEN_W];
        // Range test for one patch.
        assign pbad[g] = pen[g] &&
            ((len == '0) || ((32'(col) + 32'(len)) > 32'(PAGE_BYTES)));
    end

    assign bad = (src_par != dst_par) || (|pbad);
endmodule

// File: rtl/nand_cb_seq.sv
// Copy-back sequencer top. A state machine walks the two command phases,
// the optional readout, the patch bursts and the status read. It uses the
// cycle engine for every bus cycle and the waiter for both busy intervals.
// Assumes the device drops its ready line within GUARD_CLKS of a confirm.
module nand_cb_seq
    import nand_cb_pkg::*;
#(
    parameter int PAGE_BYTES   = 2112,
    parameter int ROW_BYTES    = 3,
    parameter int NPATCH       = 2,
    parameter int LEN_W        = 8,
    parameter int PAR_BIT      = 6,
    parameter int WE_LOW       = 2,
    parameter int WE_HIGH      = 2,
    parameter int GUARD_CLKS   = 4,
    parameter int TIMEOUT_CLKS = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ROW_BYTES*8-1:0]  src_row,
    input  logic [ROW_BYTES*8-1:0]  dst_row,
    input  logic                    readout_en,
    input  logic [NPATCH-1:0]       patch_en,
    input  logic [NPATCH*12-1:0]    patch_col,
    input  logic [NPATCH*LEN_W-1:0] patch_len,
    input  logic [NPATCH*8-1:0]     patch_fill,
    input  logic [7:0]              io_in,
    input  logic                    rb,
    output logic                    cle,
    output logic                    ale,
    output logic                    we_n,
    output logic                    re_n,
    output logic [7:0]              io_out,
    output logic                    io_oe,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    output logic                    busy,
    output logic                    done,
    output logic                    pass,
    output logic                    fail,
    output logic                    illegal,
    output logic                    timeout
);
    localparam int ROW_W    = ROW_BYTES * 8;
    localparam int ADDR_CYC = 2 + ROW_BYTES;
    localparam int IDXW     = $clog2(PAGE_BYTES);
    localparam int PIW      = $clog2(NPATCH + 1);

    typedef enum logic [4:0] {
        S_IDLE, S_CHECK, S_C00, S_ASRC, S_C35, S_W1, S_RD, S_C85, S_ADST,
        S_PSEL, S_P85, S_PCOL, S_PDAT, S_C10, S_W2, S_C70, S_STAT, S_FIN
    } st_t;

    st_t                     st;
    logic                    pend;
    logic [IDXW-1:0]         idx;
    logic [PIW-1:0]          pi;
    logic [ROW_W-1:0]        src_q, dst_q;
    logic                    rdo_q;
    logic [NPATCH-1:0]       pen_q;
    logic [NPATCH*COL_W-1:0] pcol_q;
    logic [NPATCH*LEN_W-1:0] plen_q;
    logic [NPATCH*8-1:0]     pfill_q;
    logic                    pass_q, fail_q, ill_q, tout_q;

    logic       req_bad;
    logic       eng_go, eng_done, eng_rvalid;
    logic [7:0] eng_rdata;
    logic       wt_go, wt_ok, wt_tout;
    logic       op_valid;
    bus_kind_t  op_kind;
    logic [7:0] op_byte;
    int         pidx;
    logic [COL_W-1:0] cur_col;
    logic [LEN_W-1:0] cur_len;
    logic [7:0]       cur_fill;

    nand_cb_check #(
        .PAGE_BYTES(PAGE_BYTES), .NPATCH(NPATCH), .LEN_W(LEN_W)
    ) u_check (
        .src_par(src_q[PAR_BIT]), .dst_par(dst_q[PAR_BIT]),
        .pen(pen_q), .pcol(pcol_q), .plen(plen_q), .bad(req_bad)
    );

    nand_cb_cycle #(.LOW_CLKS(WE_LOW), .HIGH_CLKS(WE_HIGH)) u_cycle (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .kind(op_kind),
        .wbyte(op_byte), .io_in(io_in), .done(eng_done),
        .rvalid(eng_rvalid), .rdata(eng_rdata), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_out(io_out), .io_oe(io_oe)
    );

    nand_cb_wait #(.GUARD_CLKS(GUARD_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_wait (
        .clk(clk), .rst_n(rst_n), .go(wt_go), .rb(rb),
        .ok(wt_ok), .tout(wt_tout)
    );

    // Current patch fields, clamped to a legal index.
    always_comb begin
        pidx     = (int'(pi) < NPATCH) ? int'(pi) : 0;
        cur_col  = pcol_q[pidx*COL_W +: COL_W];
        cur_len  = plen_q[pidx*LEN_W +: LEN_W];
        cur_fill = pfill_q[pidx*8 +: 8];
    end

    // Bus cycle selection for each state.
    always_comb begin
        op_valid = 1'b1;
        op_kind  = BK_CMD;
        op_byte  = 8'h00;
        case (st)
            S_C00:  op_byte = OP_LOAD;
            S_C35:  op_byte = OP_LOAD_GO;
            S_C85,
            S_P85:  op_byte = OP_WRITE;
            S_C10:  op_byte = OP_WRITE_GO;
            S_C70:  op_byte = OP_STATUS;
            S_ASRC, S_ADST: begin
                op_kind = BK_ADDR;
                if (int'(idx) >= 2)
                    op_byte = 8'(((st == S_ASRC) ? src_q : dst_q) >> (8 * (int'(idx) - 2)));
            end
            S_PCOL: begin
                op_kind = BK_ADDR;
                op_byte = (idx == '0) ? cur_col[7:0] : 8'(cur_col >> 8);
            end
            S_PDAT: begin
                op_kind = BK_DIN;
                op_byte = cur_fill;
            end
            S_RD, S_STAT: op_kind = BK_DOUT;
            default: op_valid = 1'b0;
        endcase
    end

    assign eng_go = op_valid && !pend;
    assign wt_go  = ((st == S_W1) || (st == S_W2)) && !pend;

    // Main sequencing: request latch, validation, phases and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            pend    <= 1'b0;
            idx     <= '0;
            pi      <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            rdo_q   <= 1'b0;
            pen_q   <= '0;
            pcol_q  <= '0;
            plen_q  <= '0;
            pfill_q <= '0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            ill_q   <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    src_q   <= src_row;
                    dst_q   <= dst_row;
                    rdo_q   <= readout_en;
                    pen_q   <= patch_en;
                    pcol_q  <= patch_col;
                    plen_q  <= patch_len;
                    pfill_q <= patch_fill;
                    pass_q  <= 1'b0;
                    fail_q  <= 1'b0;
                    ill_q   <= 1'b0;
                    tout_q  <= 1'b0;
                    st      <= S_CHECK;
                end
                S_CHECK: begin
                    idx <= '0;
                    pi  <= '0;
                    if (req_bad) begin
                        ill_q <= 1'b1;
                        st    <= S_FIN;
                    end else begin
                        st <= S_C00;
                    end
                end
                S_W1, S_W2: begin
                    if (wt_ok) begin
                        pend <= 1'b0;
                        idx  <= '0;
                        if (st == S_W2) st <= S_C70;
                        else            st <= rdo_q ? S_RD : S_C85;
                    end else if (wt_tout) begin
                        pend   <= 1'b0;
                        tout_q <= 1'b1;
                        st     <= S_FIN;
                    end else if (wt_go) begin
                        pend <= 1'b1;
                    end
                end
                S_PSEL: begin
                    idx <= '0;
                    if (pi == PIW'(NPATCH))  st <= S_C10;
                    else if (pen_q[pidx])    st <= S_P85;
                    else                     pi <= pi + 1'b1;
                end
                S_FIN: st <= S_IDLE;
                default: begin
                    if (eng_done) begin
                        pend <= 1'b0;
                        idx  <= idx + 1'b1;
                        case (st)
                            S_C00:  begin st <= S_ASRC; idx <= '0; end
                            S_ASRC: if (idx == IDXW'(ADDR_CYC - 1)) begin
                                st <= S_C35; idx <= '0;
                            end
                            S_C35:  st <= S_W1;
                            S_RD:   if (idx == IDXW'(PAGE_BYTES - 1)) begin
                                st <= S_C85; idx <= '0;
                            end
                            S_C85:  begin st <= S_ADST; idx <= '0; end
                            S_ADST: if (idx == IDXW'(ADDR_CYC - 1)) begin
                                st <= S_PSEL; pi <= '0;
                            end
                            S_P85:  begin st <= S_PCOL; idx <= '0; end
                            S_PCOL: if (idx == IDXW'(1)) begin
                                st <= S_PDAT; idx <= '0;
                            end
                            S_PDAT: if (idx == IDXW'(cur_len) - IDXW'(1)) begin
                                st <= S_PSEL; pi <= pi + 1'b1;
                            end
                            S_C10:  st <= S_W2;
                            S_C70:  st <= S_STAT;
                            S_STAT: begin
                                fail_q <= eng_rdata[0];
                                pass_q <= !eng_rdata[0];
                                st     <= S_FIN;
                            end
                            default: st <= S_IDLE;
                        endcase
                    end else if (eng_go) begin
                        pend <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign rd_data  = eng_rdata;
    assign rd_valid = eng_rvalid && (st == S_RD);
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
    assign pass     = pass_q;
    assign fail     = fail_q;
    assign illegal  = ill_q;
    assign timeout  = tout_q;
endmodule

// File: rtl/nand_cb_seq_chk.sv
// Protocol checker for the copy-back sequencer, bound to the top module.
module nand_cb_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] io_out,
    input logic       pass,
    input logic       fail,
    input logic       illegal,
    input logic       timeout
);
    // R10
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R10
    latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && re_n && !cle && !ale));
    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({pass, fail, illegal, timeout}));
endmodule

bind nand_cb_seq nand_cb_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
    .pass(pass), .fail(fail), .illegal(illegal), .timeout(timeout)
);

// File: tb/sim_nand_cb_seq.sv
// Directed bench for nand_cb_seq with a small behavioural device model.
module sim_nand_cb_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] src_row = '0, dst_row = '0;
    logic        readout_en = 1'b0;
    logic [1:0]  patch_en = '0;
    logic [23:0] patch_col = '0;
    logic [15:0] patch_len = '0;
    logic [15:0] patch_fill = '0;
    logic [7:0]  io_in = '0;
    logic        rb = 1'b1;
    logic        cle, ale, we_n, re_n, io_oe, rd_valid;
    logic        busy, done, pass, fail, illegal, timeout;
    logic [7:0]  io_out, rd_data;

    int checks = 0, errors = 0, cyc = 0;

    nand_cb_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_row(src_row),
        .dst_row(dst_row), .readout_en(readout_en), .patch_en(patch_en),
        .patch_col(patch_col), .patch_len(patch_len), .patch_fill(patch_fill),
        .io_in(io_in), .rb(rb), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .illegal(illegal), .timeout(timeout)
    );

    always #10 clk = ~clk;

    // Device model state.
    logic [9:0] wlog [512];
    int  n_log = 0, busy_left = 0, ptr = 0, rd_idx = 0, rd_bad = 0, rd_n = 0;
    int  viol = 0, wl = 0, wbad = 0;
    bit  stat_mode = 0, stuck = 0, we_prev = 1, re_prev = 1;
    logic [7:0] stat_val = 8'h00;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    // Behavioural device: logs write cycles, models busy, serves read data.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy_left > 0) busy_left--;
            rb = (busy_left == 0) && !stuck;
            if (!we_n) wl++;
            else if (wl != 0) begin
                if (wl != 2) wbad++;
                wl = 0;
            end
            if (!we_prev && we_n) begin
                if (!rb) viol++;
                wlog[n_log % 512] = {cle, ale, io_out};
                n_log++;
                if (cle && io_out == 8'h00) begin ptr = 0; rd_idx = 0; stat_mode = 0; end
                if (cle && io_out == 8'h70) stat_mode = 1;
                if (cle && io_out == 8'h35) begin busy_left = 20; rb = 0; end
                if (cle && io_out == 8'h10) begin busy_left = 40; rb = 0; end
            end
            if (!re_prev && re_n) begin
                if (!rb) viol++;
                if (!stat_mode) ptr++;
            end
            if (rd_valid) begin
                if (rd_data != pat(rd_idx)) rd_bad++;
                rd_idx++;
                rd_n++;
            end
            io_in = stat_mode ? stat_val : pat(ptr);
            we_prev = we_n;
            re_prev = re_n;
        end
    end

    // Expected write log.
    logic [9:0] exp_q [512];
    int n_exp = 0;

    task automatic push(input bit c, input bit a, input logic [7:0] b);
        exp_q[n_exp] = {c, a, b};
        n_exp++;
    endtask

    task automatic push_addr(input logic [23:0] row);
        push(0, 1, 8'h00); push(0, 1, 8'h00);
        push(0, 1, row[7:0]); push(0, 1, row[15:8]); push(0, 1, row[23:16]);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cmp_log(input int base, input string req);
        int bad_at = -1;
        if (n_log - base == n_exp) begin
            for (int i = 0; i < n_exp; i++)
                if (bad_at < 0 && wlog[(base + i) % 512] != exp_q[i]) bad_at = i;
        end
        check((n_log - base == n_exp) && bad_at < 0, req, "bus log length/first bad index",
              (bad_at < 0) ? n_log - base : bad_at, n_exp);
        if (bad_at >= 0)
            $display("  entry %0d actual %h expected %h", bad_at,
                     wlog[(base + bad_at) % 512], exp_q[bad_at]);
    endtask

    task automatic run(output int waited);
        waited = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", busy, 1);
        while (!done && waited < 30000) begin
            @(negedge clk); waited++;
        end
    endtask

    task automatic finish_run(input string req, input int expect_flag);
        int flags;
        flags = {pass, fail, illegal, timeout};
        check(done && flags == expect_flag, req, "result flags pass/fail/illegal/timeout",
              flags, expect_flag);
        @(negedge clk);
        check(!busy && !done, "R11", "idle after done", busy, 0);
    endtask

    task automatic t_reset;
        check(we_n && re_n && !cle && !ale && !busy && !done, "R11", "reset bus state",
              {we_n, re_n, cle, ale, busy, done}, 6'b110000);
    endtask

    task automatic t_basic;
        int base, w, rb0;
        src_row = 24'h000140; dst_row = 24'h0023C0;
        readout_en = 0; patch_en = 0; stat_val = 8'h00;
        base = n_log; rb0 = rd_n; n_exp = 0;
        push(1, 0, 8'h00); push_addr(src_row); push(1, 0, 8'h35);
        push(1, 0, 8'h85); push_addr(dst_row); push(1, 0, 8'h10); push(1, 0, 8'h70);
        run(w);
        finish_run("R6", 4'b1000);
        cmp_log(base, "R1 R4");
        check(rd_n == rb0, "R3", "no readout when flag clear", rd_n - rb0, 0);
        check(wbad == 0, "R10", "WE# low width violations", wbad, 0);
    endtask

    task automatic t_readout;
        int base, w, rb0, bad0, v0;
        readout_en = 1; patch_en = 0; stat_val = 8'h00;
        base = n_log; rb0 = rd_n; bad0 = rd_bad; v0 = viol; n_exp = 0;
        push(1, 0, 8'h00); push_addr(src_row); push(1, 0, 8'h35);
        push(1, 0, 8'h85); push_addr(dst_row); push(1, 0, 8'h10); push(1, 0, 8'h70);
        run(w);
        finish_run("R3", 4'b1000);
        check(rd_n - rb0 == 2112, "R3", "readout byte count", rd_n - rb0, 2112);
        check(rd_bad == bad0, "R3", "readout data mismatches", rd_bad - bad0, 0);
        check(viol == v0, "R2", "strobes while busy", viol - v0, 0);
        cmp_log(base, "R4");
        readout_en = 0;
    endtask

    task automatic t_patch;
        int base, w;
        patch_en   = 2'b10;
        patch_col  = {12'd2109, 12'd3000};
        patch_len  = {8'd3, 8'd0};
        patch_fill = {8'h55, 8'hAA};
        stat_val = 8'h00; base = n_log; n_exp = 0;
        push(1, 0, 8'h00); push_addr(src_row); push(1, 0, 8'h35);
        push(1, 0, 8'h85); push_addr(dst_row);
        push(1, 0, 8'h85); push(0, 1, 8'h3D); push(0, 1, 8'h08);
        for (int i = 0; i < 3; i++) push(0, 0, 8'h55);
        push(1, 0, 8'h10); push(1, 0, 8'h70);
        run(w);
        finish_run("R8", 4'b1000);
        cmp_log(base, "R5 skip and end-of-page patch");
        patch_en  = 2'b11;
        patch_col = {12'd2109, 12'd5};
        patch_len = {8'd3, 8'd2};
        base = n_log; n_exp = 0;
        push(1, 0, 8'h00); push_addr(src_row); push(1, 0, 8'h35);
        push(1, 0, 8'h85); push_addr(dst_row);
        push(1, 0, 8'h85); push(0, 1, 8'h05); push(0, 1, 8'h00);
        push(0, 0, 8'hAA); push(0, 0, 8'hAA);
        push(1, 0, 8'h85); push(0, 1, 8'h3D); push(0, 1, 8'h08);
        for (int i = 0; i < 3; i++) push(0, 0, 8'h55);
        push(1, 0, 8'h10); push(1, 0, 8'h70);
        run(w);
        finish_run("R5", 4'b1000);
        cmp_log(base, "R5 two patches in order");
        patch_en = 0;
    endtask

    task automatic t_status_fail;
        int w;
        stat_val = 8'hC1;
        run(w);
        finish_run("R6", 4'b0100);
        stat_val = 8'hFE;
        run(w);
        finish_run("R6", 4'b1000);
        stat_val = 8'h00;
    endtask

    task automatic t_illegal;
        int base, w;
        base = n_log;
        dst_row = 24'h000280;
        run(w);
        finish_run("R7", 4'b0010);
        check(n_log == base, "R7", "bus cycles on parity mismatch", n_log - base, 0);
        dst_row = 24'h0023C0;
        patch_en = 2'b01; patch_col = {12'd0, 12'd2110}; patch_len = {8'd0, 8'd3};
        run(w);
        finish_run("R8", 4'b0010);
        check(n_log == base, "R8", "bus cycles on patch past end", n_log - base, 0);
        patch_col = {12'd0, 12'd10}; patch_len = {8'd0, 8'd0};
        run(w);
        finish_run("R8", 4'b0010);
        check(n_log == base, "R8", "bus cycles on empty patch", n_log - base, 0);
        patch_en = 0;
    endtask

    task automatic t_timeout;
        int base, w;
        stuck = 1; base = n_log; n_exp = 0;
        push(1, 0, 8'h00); push_addr(src_row); push(1, 0, 8'h35);
        run(w);
        finish_run("R9", 4'b0001);
        repeat (10) @(negedge clk);
        cmp_log(base, "R9 stop after first confirm");
        stuck = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_readout();
        t_patch();
        t_status_fail();
        t_illegal();
        t_timeout();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule